// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Unit

This block holds the interrupt presentation state of one processor. A 32-bit presentation word combines the processor's current priority (bits 31:24) with the number of the pending source (bits 23:0). Alongside it the unit keeps the priority of the pending interrupt and the requested priority of an inter-processor interrupt (IPI). Lower priority values are more favoured. The value 0xFF means "none".

A source unit offers interrupts as a source number and a priority. The unit takes an offer or bounces it back with a reject strobe. An interrupt that is pushed out of the pending slot is also bounced back. The processor drives one-cycle commands: write its priority, write the IPI priority, accept, end-of-interrupt and poll. Accept and poll return the presentation word and the IPI priority. End-of-interrupt is forwarded to the source unit. When the unit has nothing pending after a priority change, it asks the source unit to resend. A command and an offer may arrive in the same cycle. In that case the command is applied first, and the offer is then judged against the updated state.

Top module: `irq_present_unit`

## Requirements
- R1: A synchronous active-low reset clears the presentation word to 0, sets the pending priority and the IPI priority to 0xFF, lowers `irq_out` and clears every strobe.
- R2: Commands use `cmd_op` codes 0 = write priority, 1 = write IPI priority, 2 = accept, 3 = end-of-interrupt, 4 = poll; codes 5 to 7 have no effect. Poll returns the word `{priority[31:24], source[23:0]}` on `rsp_word` and the IPI priority on `rsp_ipi_prio`, and changes no state.
- R3: An offer is refused, with its own number on the offer reject lane, when its priority is not below the current priority, or when a pending interrupt already has an equal or lower priority value.
- R4: A taken offer rejects any displaced source on the offer reject lane, latches the new number and priority, and raises `irq_out`.
- R5: Accept returns the word as it was, lowers `irq_out`, moves the pending priority into the priority field, clears the source field and sets the pending priority to 0xFF.
- R6: Writing a priority below the old one evicts a pending interrupt whose priority is not below the new value. The eviction rejects that interrupt on the command reject lane, clears it and lowers `irq_out`.
- R7: Writing a priority equal to or above the old one with nothing pending pulses `resend_req`. It also presents an IPI if the IPI priority is below the new priority.
- R8: Writing an IPI priority below the current priority presents source `IPI_SRC` (default 2) at that priority, unless the pending interrupt's priority value is equal or lower. A displaced source goes out on the command reject lane.
- R9: End-of-interrupt loads the priority field from `cmd_data[31:24]` and pulses `eoi_valid` with `cmd_data[23:0]`. With nothing pending it also pulses `resend_req` and re-checks the IPI against the new priority.
- R10: When a command and an offer share a cycle, the command acts first and the offer is judged on the resulting state. Each stage has its own reject lane, so two rejects can come out together.
- R11: An offer with source number 0 is ignored.
- R12: Every result appears on the cycle after its inputs. Strobes last one cycle. `irq_out` is high exactly when the source field is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| offer_valid | input | 1 | An interrupt is offered this cycle |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| cmd_valid | input | 1 | A processor command is issued this cycle |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_data | input | 32 | Command operand |
| irq_out | output | 1 | Interrupt line to the processor |
| rsp_valid | output | 1 | Accept or poll response is valid |
| rsp_word | output | 32 | Returned presentation word |
| rsp_ipi_prio | output | 8 | Returned IPI priority |
| rej_cmd_valid | output | 1 | Reject caused by a command |
| rej_cmd_src | output | 24 | Source rejected by a command |
| rej_offer_valid | output | 1 | Reject caused by an offer |
| rej_offer_src | output | 24 | Source rejected by an offer |
| eoi_valid | output | 1 | End-of-interrupt to the source unit |
| eoi_src | output | 24 | Source number of the end-of-interrupt |
| resend_req | output | 1 | Request to the source unit to resend |

## Verification
A processor command and a source offer can land in the same cycle. Both touch the pending slot, so their order decides which source is bounced. The bench provokes the overlap in two ways. First, it writes an IPI priority that displaces a pending source while a weaker offer arrives; both reject lanes must fire with the right numbers. Second, it accepts while a stronger offer arrives; the response must show the old word, the offer must end up pending against the priority just restored, and a following poll must show it.

// File: rtl/irqp_pkg.sv
// Package: shared types, command codes and the IPI presentation helper
// for the per-processor interrupt presentation unit.
// Assumes an 8-bit priority and a 24-bit source number packed in a 32-bit word.
package irqp_pkg;

    localparam int PRIO_W = 8;
    localparam int SRC_W  = 24;
    localparam int WORD_W = PRIO_W + SRC_W;
    localparam int OP_W   = 3;

    localparam logic [PRIO_W-1:0] PRIO_NONE = {PRIO_W{1'b1}};

    typedef enum logic [OP_W-1:0] {
        OP_SET_PRIO = 3'd0,
        OP_SET_IPI  = 3'd1,
        OP_ACCEPT   = 3'd2,
        OP_EOI      = 3'd3,
        OP_POLL     = 3'd4
    } op_e;

    // Architectural presentation state
    typedef struct packed {
        logic [PRIO_W-1:0] cur_prio;
        logic [SRC_W-1:0]  src;
        logic [PRIO_W-1:0] pend_prio;
        logic [PRIO_W-1:0] ipi_prio;
    } pstate_t;

    // A source number travelling back to the source unit
    typedef struct packed {
        logic             valid;
        logic [SRC_W-1:0] src;
    } srcmsg_t;

    // Everything the unit registers towards its outputs besides the line
    typedef struct packed {
        srcmsg_t           rej_cmd;
        srcmsg_t           rej_offer;
        srcmsg_t           eoi;
        logic              resend;
        logic              rsp_valid;
        logic [WORD_W-1:0] rsp_word;
        logic [PRIO_W-1:0] rsp_ipi;
    } outs_t;

    // Present an IPI unless the pending interrupt is already as favoured.
    function automatic void ipi_present(
        input  pstate_t          s,
        input  logic             line,
        input  logic [SRC_W-1:0] ipi_src,
        output pstate_t          ns,
        output logic             nline,
        output srcmsg_t          rej
    );
        ns    = s;
        nline = line;
        rej   = '0;
        if (!((s.src != '0) && (s.pend_prio <= s.ipi_prio))) begin
            if (s.src != '0) begin
                rej.valid = 1'b1;
                rej.src   = s.src;
            end
            ns.src       = ipi_src;
            ns.pend_prio = s.ipi_prio;
            nline        = 1'b1;
        end
    endfunction

endpackage

// File: rtl/irqp_cmd_stage.sv
// Command stage: applies one processor command to the presentation state.
// Purely combinational; the caller registers the results.
// Assumes at most one command per cycle and that IPI_SRC is non-zero.
module irqp_cmd_stage
    import irqp_pkg::*;
#(
    parameter logic [SRC_W-1:0] IPI_SRC = 24'd2
) (
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [WORD_W-1:0] cmd_data,
    input  pstate_t           s_in,
    input  logic              line_in,
    output pstate_t           s_out,
    output logic              line_out,
    output srcmsg_t           rej,
    output srcmsg_t           eoi,
    output logic              resend,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_word,
    output logic [PRIO_W-1:0] rsp_ipi
);

    logic [PRIO_W-1:0] new_prio;
    pstate_t           ipi_s;
    logic              ipi_line;
    srcmsg_t           ipi_rej;
    pstate_t           work_s;

    assign new_prio = cmd_data[PRIO_W-1:0];

    // Decode the command and compute the next state, strobes and response
    always_comb begin
        s_out     = s_in;
        line_out  = line_in;
        rej       = '0;
        eoi       = '0;
        resend    = 1'b0;
        rsp_valid = 1'b0;
        rsp_word  = '0;
        rsp_ipi   = '0;
        work_s    = s_in;
        ipi_s     = s_in;
        ipi_line  = line_in;
        ipi_rej   = '0;
        if (cmd_valid) begin
            case (cmd_op)
                OP_SET_PRIO: begin
                    work_s.cur_prio = new_prio;
                    s_out = work_s;
                    if (new_prio < s_in.cur_prio) begin
                        if ((s_in.src != '0) && (new_prio <= s_in.pend_prio)) begin
                            rej.valid       = 1'b1;
                            rej.src         = s_in.src;
                            s_out.src       = '0;
                            s_out.pend_prio = PRIO_NONE;
                            line_out        = 1'b0;
                        end
                    end else if (s_in.src == '0) begin
                        resend = 1'b1;
                        if (s_in.ipi_prio < new_prio) begin
                            ipi_present(work_s, line_in, IPI_SRC, ipi_s, ipi_line, ipi_rej);
                            s_out    = ipi_s;
                            line_out = ipi_line;
                            rej      = ipi_rej;
                        end
                    end
                end
                OP_SET_IPI: begin
                    work_s.ipi_prio = new_prio;
                    s_out = work_s;
                    if (new_prio < s_in.cur_prio) begin
                        ipi_present(work_s, line_in, IPI_SRC, ipi_s, ipi_line, ipi_rej);
                        s_out    = ipi_s;
                        line_out = ipi_line;
                        rej      = ipi_rej;
                    end
                end
                OP_ACCEPT: begin
                    rsp_valid       = 1'b1;
                    rsp_word        = {s_in.cur_prio, s_in.src};
                    rsp_ipi         = s_in.ipi_prio;
                    s_out.cur_prio  = s_in.pend_prio;
                    s_out.src       = '0;
                    s_out.pend_prio = PRIO_NONE;
                    line_out        = 1'b0;
                end
                OP_EOI: begin
                    work_s.cur_prio = cmd_data[WORD_W-1:SRC_W];
                    s_out     = work_s;
                    eoi.valid = 1'b1;
                    eoi.src   = cmd_data[SRC_W-1:0];
                    if (s_in.src == '0) begin
                        resend = 1'b1;
                        if (s_in.ipi_prio < work_s.cur_prio) begin
                            ipi_present(work_s, line_in, IPI_SRC, ipi_s, ipi_line, ipi_rej);
                            s_out    = ipi_s;
                            line_out = ipi_line;
                            rej      = ipi_rej;
                        end
                    end
                end
                OP_POLL: begin
                    rsp_valid = 1'b1;
                    rsp_word  = {s_in.cur_prio, s_in.src};
                    rsp_ipi   = s_in.ipi_prio;
                end
                default: begin
                    s_out = s_in;
                end
            endcase
        end
    end

endmodule

// File: rtl/irqp_offer_stage.sv
// Offer stage: judges an offered interrupt against the state the command
// stage left. Purely combinational.
// Assumes source number 0 never names a real source, so such offers are dropped.
module irqp_offer_stage
    import irqp_pkg::*;
(
    input  logic              offer_valid,
    input  logic [SRC_W-1:0]  offer_src,
    input  logic [PRIO_W-1:0] offer_prio,
    input  pstate_t           s_in,
    input  logic              line_in,
    output pstate_t           s_out,
    output logic              line_out,
    output srcmsg_t           rej
);

    logic refuse;

    // Refusal test: not better than the processor or not better than the pending one
    always_comb begin
        refuse = (offer_prio >= s_in.cur_prio) ||
                 ((s_in.src != '0) && (s_in.pend_prio <= offer_prio));
    end

    // Take or bounce the offer
    always_comb begin
        s_out    = s_in;
        line_out = line_in;
        rej      = '0;
        if (offer_valid && (offer_src != '0)) begin
            if (refuse) begin
                rej.valid = 1'b1;
                rej.src   = offer_src;
            end else begin
                if (s_in.src != '0) begin
                    rej.valid = 1'b1;
                    rej.src   = s_in.src;
                end
                s_out.src       = offer_src;
                s_out.pend_prio = offer_prio;
                line_out        = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irqp_out_reg.sv
// Output register: holds strobes and responses for exactly one cycle.
// Assumes a synchronous active-low reset.
module irqp_out_reg
    import irqp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  outs_t d,
    output outs_t q
);

    // Capture this cycle's results; everything clears on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/irq_present_unit.sv
// Per-processor interrupt presentation unit. It holds the presentation word,
// the pending priority and the IPI priority. Each cycle it applies one command,
// then one offer, and registers the results.
// Assumes the source unit tolerates two rejects in one cycle (one per lane).
module irq_present_unit
    import irqp_pkg::*;
#(
    parameter logic [23:0] IPI_SRC = 24'd2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        offer_valid,
    input  logic [23:0] offer_src,
    input  logic [7:0]  offer_prio,
    input  logic        cmd_valid,
    input  logic [2:0]  cmd_op,
    input  logic [31:0] cmd_data,
    output logic        irq_out,
    output logic        rsp_valid,
    output logic [31:0] rsp_word,
    output logic [7:0]  rsp_ipi_prio,
    output logic        rej_cmd_valid,
    output logic [23:0] rej_cmd_src,
    output logic        rej_offer_valid,
    output logic [23:0] rej_offer_src,
    output logic        eoi_valid,
    output logic [23:0] eoi_src,
    output logic        resend_req
);

    localparam pstate_t RESET_STATE = '{cur_prio: '0, src: '0,
                                        pend_prio: PRIO_NONE, ipi_prio: PRIO_NONE};

    pstate_t state_q;
    logic    line_q;
    pstate_t cmd_s;
    logic    cmd_line;
    pstate_t off_s;
    logic    off_line;
    outs_t   outs_d;
    outs_t   outs_q;

    irqp_cmd_stage #(.IPI_SRC(IPI_SRC)) u_cmd (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_data  (cmd_data),
        .s_in      (state_q),
        .line_in   (line_q),
        .s_out     (cmd_s),
        .line_out  (cmd_line),
        .rej       (outs_d.rej_cmd),
        .eoi       (outs_d.eoi),
        .resend    (outs_d.resend),
        .rsp_valid (outs_d.rsp_valid),
        .rsp_word  (outs_d.rsp_word),
        .rsp_ipi   (outs_d.rsp_ipi)
    );

    irqp_offer_stage u_offer (
        .offer_valid (offer_valid),
        .offer_src   (offer_src),
        .offer_prio  (offer_prio),
        .s_in        (cmd_s),
        .line_in     (cmd_line),
        .s_out       (off_s),
        .line_out    (off_line),
        .rej         (outs_d.rej_offer)
    );

    irqp_out_reg u_outs (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (outs_d),
        .q     (outs_q)
    );

    // Presentation state and interrupt line update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RESET_STATE;
            line_q  <= 1'b0;
        end else begin
            state_q <= off_s;
            line_q  <= off_line;
        end
    end

    assign irq_out         = line_q;
    assign rsp_valid       = outs_q.rsp_valid;
    assign rsp_word        = outs_q.rsp_word;
    assign rsp_ipi_prio    = outs_q.rsp_ipi;
    assign rej_cmd_valid   = outs_q.rej_cmd.valid;
    assign rej_cmd_src     = outs_q.rej_cmd.src;
    assign rej_offer_valid = outs_q.rej_offer.valid;
    assign rej_offer_src   = outs_q.rej_offer.src;
    assign eoi_valid       = outs_q.eoi.valid;
    assign eoi_src         = outs_q.eoi.src;
    assign resend_req      = outs_q.resend;

    // R12
    line_tracks_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (state_q.src != '0));

    // R3
    offer_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (offer_valid && !cmd_valid && (offer_src != '0) && (offer_prio >= state_q.cur_prio))
        |=> (rej_offer_valid && (rej_offer_src == $past(offer_src))));

    // R5
    accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OP_ACCEPT) && !offer_valid)
        |=> (!irq_out && (state_q.src == '0) && rsp_valid));

    // R9
    eoi_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OP_EOI))
        |=> (eoi_valid && (eoi_src == $past(cmd_data[23:0]))));

    // R2
    poll_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OP_POLL) && !offer_valid)
        |=> ($stable(state_q) && rsp_valid));

    // R11
    zero_src_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (offer_valid && (offer_src == '0) && !cmd_valid)
        |=> (!rej_offer_valid && $stable(state_q)));

    // R6
    evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OP_SET_PRIO) && !offer_valid && (state_q.src != '0) &&
         (cmd_data[7:0] < state_q.cur_prio) && (cmd_data[7:0] <= state_q.pend_prio))
        |=> (!irq_out && rej_cmd_valid && (rej_cmd_src == $past(state_q.src))));

endmodule

// File: tb/irq_present_unit_test.sv
module irq_present_unit_test;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0]  tag;
        logic        ov;
        logic [23:0] osrc;
        logic [7:0]  opri;
        logic        cv;
        logic [2:0]  op;
        logic [31:0] data;
        logic        irq;
        logic        rcv;
        logic [23:0] rcs;
        logic        rov;
        logic [23:0] ros;
        logic        ev;
        logic [23:0] es;
        logic        rs;
        logic        rspv;
        logic [31:0] rspw;
        logic [7:0]  rspi;
    } vec_t;

    localparam int NV = 36;
    // tag: requirement number; op codes 0 prio, 1 ipi, 2 accept, 3 eoi, 4 poll
    localparam vec_t TBL [NV] = '{
        '{8'd3,  1'b1,24'h10,8'h05, 1'b0,3'd0,32'h0,        1'b0, 1'b0,24'h0, 1'b1,24'h10, 1'b0,24'h0, 1'b0, 1'b0,32'h0,8'h0},        // R3 priority 0 refuses all
        '{8'd7,  1'b0,24'h0,8'h00,  1'b1,3'd0,32'hFF,       1'b0, 1'b0,24'h0, 1'b0,24'h0,  1'b0,24'h0, 1'b1, 1'b0,32'h0,8'h0},        // R7 raise -> resend
        '{8'd4,  1'b1,24'h10,8'h05, 1'b0,3'd0,32'h0,        1'b1, 1'b0,24'h0, 1'b0,24'h0,  1'b0,24'h0, 1'b0, 1'b0,32'h0,8'h0},        // R4 taken
        '{8'd3,  1'b1,24'h11,8'h07, 1'b0,3'd0,32'h0,        1'b1, 1'b0,24'h0, 1'b1,24'h11, 1'b0,24'h0, 1'b0, 1'b0,32'h0,8'h0},        // R3 weaker than pending
        '{8'd4,  1'b1,24'h12,8'h03, 1'b0,3'd0,32'h0,        1'b1, 1'b0,24'h0, 1'b1,24'h10, 1'b0,24'h0, 1'b0, 1'b0,32'h0,8'h0},        // R4 displaces 0x10
        '{8'd2,  1'b0,24'h0,8'h00,  1'b1,3'd4,32'h0,        1'b1, 1'b0,24'h0, 1'b0,24'h0,  1'b0,24'h0, 1'b0, 1'b1,32'hFF000012,8'hFF}, // R2 poll
        '{8'd3,  1'b1,24'h13,8'h03, 1'b0,3'd0,32'h0,        1'b1, 1'b0,24'h0, 1'b1,24'h13, 1'b0,24'h0, 1'b0, 1'b0,32'h0,8'h0},        // R3 equal to pending
        '{8'd5,  1'b0,24'h0,8'h00,  1'b1,3'd2,32'h0,        1'b0, 1'b0,24'h0, 1'b0,24'h0,  1'b0,24'h0, 1'b0, 1'b1,32'hFF000012,8'hFF}, // R5 accept
        '{8'd2,  1'b0,24'h0,8'h00,  1'b1,3'd4,32'h0,        1'b0, 1'b0,24'h0, 1'b0,24'h0,  1'b0,24'h0, 1'b0, 1'b1,32'h03000000,8'hFF}, // R2 poll after accept
        '{8'd3,  1'b1,24'h14,8'h03, 1'b0,3'd0,32'h0,        1'b0, 1'b0,24'h0, 1'b1,24'h14, 1'b0,24'h0, 1'b0, 1'b0,32'h0,8'h0},        // R3 equal to processor
        '{8'd4,  1'b1,24'h14,8'h02, 1'b0,3'd0,32'h0,        1'b1, 1'b0,24'h0, 1'b0,24'h0,  1'b0,24'h0, 1'b0, 1'b0,32'h0,8'h0},        // R4
        '{8'd6,  1'b0,24'h0,8'h00,  1'b1,3'd0,32'h02,       1'b0, 1'b1,24'h14, 1'b0,24'h0, 1'b0,24'h0, 1'b0, 1'b0,32'h0,8'h0},        // R6 evict
        '{8'd8,  1'b0,24'h0,8'h00,  1'b1,3'd1,32'h01,       1'b1, 1'b0,24'h0, 1'b0,24'h0,  1'b0,24'h0, 1'b0, 1'b0,32'h0,8'h0},        // R8 IPI raised
        '{8'd2,  1'b0,24'h0,8'h00,  1'b1,3'd4,32'h0,        1'b1, 1'b0,24'h0, 1'b0,24'h0,  1'b0,24'h0, 1'b0, 1'b1,32'h02000002,8'h01}, // R2
        '{8'd5,  1'b0,24'h0,8'h00,  1'b1,3'd2,32'h0,        1'b0, 1'b0,24'h0, 1'b0,24'h0,  1'b0,24'h0, 1'b0, 1'b1,32'h02000002,8'h01}, // R5
        '{8'd9,  1'b0,24'h0,8'h00,  1'b1,3'd3,32'h02000002, 1'b1, 1'b0,24'h0, 1'b0,24'h0,  1'b1,24'h2, 1'b1, 1'b0,32'h0,8'h0},        // R9 eoi re-presents IPI
        '{8'd8,  1'b0,24'h0,8'h00,  1'b1,3'd1,32'hFF,       1'b1, 1'b0,24'h0, 1'b0,24'h0,  1'b0,24'h0, 1'b0, 1'b0,32'h0,8'h0},        // R8 no effect
        '{8'd5,  1'b0,24'h0,8'h00,  1'b1,3'd2,32'h0,        1'b0, 1'b0,24'h0, 1'b0,24'h0,  1'b0,24'h0, 1'b0, 1'b1,32'h02000002,8'hFF}, // R5
        '{8'd9,  1'b0,24'h0,8'h00,  1'b1,3'd3,32'hFF000002, 1'b0, 1'b0,24'h0, 1'b0,24'h0,  1'b1,24'h2, 1'b1, 1'b0,32'h0,8'h0},        // R9
        '{8'd4,  1'b1,24'h20,8'h06, 1'b0,3'd0,32'h0,        1'b1, 1'b0,24'h0, 1'b0,24'h0,  1'b0,24'h0, 1'b0, 1'b0,32'h0,8'h0},        // R4
        '{8'd10, 1'b1,24'h21,8'h05, 1'b1,3'd1,32'h04,       1'b1, 1'b1,24'h20, 1'b1,24'h21, 1'b0,24'h0, 1'b0, 1'b0,32'h0,8'h0},       // R10 two rejects
        '{8'd2,  1'b0,24'h0,8'h00,  1'b1,3'd4,32'h0,        1'b1, 1'b0,24'h0, 1'b0,24'h0,  1'b0,24'h0, 1'b0, 1'b1,32'hFF000002,8'h04}, // R2
        '{8'd10, 1'b1,24'h22,8'h01, 1'b1,3'd2,32'h0,        1'b1, 1'b0,24'h0, 1'b0,24'h0,  1'b0,24'h0, 1'b0, 1'b1,32'hFF000002,8'h04}, // R10 accept + offer
        '{8'd2,  1'b0,24'h0,8'h00,  1'b1,3'd4,32'h0,        1'b1, 1'b0,24'h0, 1'b0,24'h0,  1'b0,24'h0, 1'b0, 1'b1,32'h04000022,8'h04}, // R2
        '{8'd8,  1'b0,24'h0,8'h00,  1'b1,3'd1,32'h00,       1'b1, 1'b1,24'h22, 1'b0,24'h0, 1'b0,24'h0, 1'b0, 1'b0,32'h0,8'h0},        // R8 displaces 0x22
        '{8'd6,  1'b0,24'h0,8'h00,  1'b1,3'd0,32'h00,       1'b0, 1'b1,24'h02, 1'b0,24'h0, 1'b0,24'h0, 1'b0, 1'b0,32'h0,8'h0},        // R6 evicts IPI
        '{8'd7,  1'b0,24'h0,8'h00,  1'b1,3'd0,32'h00,       1'b0, 1'b0,24'h0, 1'b0,24'h0,  1'b0,24'h0, 1'b1, 1'b0,32'h0,8'h0},        // R7 equal -> resend
        '{8'd2,  1'b0,24'h0,8'h00,  1'b1,3'd7,32'hFFFFFFFF, 1'b0, 1'b0,24'h0, 1'b0,24'h0,  1'b0,24'h0, 1'b0, 1'b0,32'h0,8'h0},        // R2 unused code
        '{8'd2,  1'b0,24'h0,8'h00,  1'b1,3'd4,32'h0,        1'b0, 1'b0,24'h0, 1'b0,24'h0,  1'b0,24'h0, 1'b0, 1'b1,32'h00000000,8'h00}, // R2 state untouched
        '{8'd8,  1'b0,24'h0,8'h00,  1'b1,3'd1,32'hFF,       1'b0, 1'b0,24'h0, 1'b0,24'h0,  1'b0,24'h0, 1'b0, 1'b0,32'h0,8'h0},        // R8
        '{8'd7,  1'b0,24'h0,8'h00,  1'b1,3'd0,32'hFF,       1'b0, 1'b0,24'h0, 1'b0,24'h0,  1'b0,24'h0, 1'b1, 1'b0,32'h0,8'h0},        // R7
        '{8'd11, 1'b1,24'h00,8'h01, 1'b0,3'd0,32'h0,        1'b0, 1'b0,24'h0, 1'b0,24'h0,  1'b0,24'h0, 1'b0, 1'b0,32'h0,8'h0},        // R11 zero source
        '{8'd11, 1'b0,24'h0,8'h00,  1'b1,3'd4,32'h0,        1'b0, 1'b0,24'h0, 1'b0,24'h0,  1'b0,24'h0, 1'b0, 1'b1,32'hFF000000,8'hFF}, // R11 nothing latched
        '{8'd4,  1'b1,24'h30,8'h09, 1'b0,3'd0,32'h0,        1'b1, 1'b0,24'h0, 1'b0,24'h0,  1'b0,24'h0, 1'b0, 1'b0,32'h0,8'h0},        // R4
        '{8'd9,  1'b0,24'h0,8'h00,  1'b1,3'd3,32'h05000031, 1'b1, 1'b0,24'h0, 1'b0,24'h0,  1'b1,24'h31, 1'b0, 1'b0,32'h0,8'h0},       // R9 pending -> no resend
        '{8'd2,  1'b0,24'h0,8'h00,  1'b1,3'd4,32'h0,        1'b1, 1'b0,24'h0, 1'b0,24'h0,  1'b0,24'h0, 1'b0, 1'b1,32'h05000030,8'hFF}  // R2
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        offer_valid = 1'b0;
    logic [23:0] offer_src = '0;
    logic [7:0]  offer_prio = '0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [31:0] cmd_data = '0;
    logic        irq_out, rsp_valid, rej_cmd_valid, rej_offer_valid, eoi_valid, resend_req;
    logic [31:0] rsp_word;
    logic [7:0]  rsp_ipi_prio;
    logic [23:0] rej_cmd_src, rej_offer_src, eoi_src;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    irq_present_unit uut (
        .clk(clk), .rst_n(rst_n),
        .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .irq_out(irq_out), .rsp_valid(rsp_valid), .rsp_word(rsp_word), .rsp_ipi_prio(rsp_ipi_prio),
        .rej_cmd_valid(rej_cmd_valid), .rej_cmd_src(rej_cmd_src),
        .rej_offer_valid(rej_offer_valid), .rej_offer_src(rej_offer_src),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_req(resend_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string tag_name(input logic [7:0] t);
        case (t)
            8'd1: return "R1";   8'd2: return "R2";   8'd3: return "R3";
            8'd4: return "R4";   8'd5: return "R5";   8'd6: return "R6";
            8'd7: return "R7";   8'd8: return "R8";   8'd9: return "R9";
            8'd10: return "R10"; 8'd11: return "R11"; default: return "R12";
        endcase
    endfunction

    function automatic logic [117:0] observed();
        return {irq_out, rej_cmd_valid, rej_cmd_src, rej_offer_valid, rej_offer_src,
                eoi_valid, eoi_src, resend_req, rsp_valid, rsp_word, rsp_ipi_prio};
    endfunction

    task automatic check(input string req, input logic [117:0] got, input logic [117:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Apply inputs for one clock, then return to idle and settle past the edge
    task automatic step(input logic ov, input logic [23:0] os, input logic [7:0] op_pri,
                        input logic cv, input logic [2:0] op, input logic [31:0] d);
        offer_valid = ov; offer_src = os; offer_prio = op_pri;
        cmd_valid = cv; cmd_op = op; cmd_data = d;
        @(posedge clk);
        #1;
        offer_valid = 1'b0; offer_src = '0; offer_prio = '0;
        cmd_valid = 1'b0; cmd_op = '0; cmd_data = '0;
    endtask

    function automatic logic [117:0] expect_of(input vec_t v);
        return {v.irq, v.rcv, v.rcs, v.rov, v.ros, v.ev, v.es, v.rs, v.rspv, v.rspw, v.rspi};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1 reset state at the ports
        check("R1", observed(), '0);
        step(1'b0, '0, '0, 1'b1, 3'd4, '0);
        check("R1", observed(), {1'b0, 1'b0, 24'h0, 1'b0, 24'h0, 1'b0, 24'h0, 1'b0, 1'b1, 32'h0, 8'hFF});

        for (int i = 0; i < NV; i++) begin
            step(TBL[i].ov, TBL[i].osrc, TBL[i].opri, TBL[i].cv, TBL[i].op, TBL[i].data);
            check(tag_name(TBL[i].tag), observed(), expect_of(TBL[i]));
        end

        // R12 strobes last one cycle, line holds with pending source 0x30
        step(1'b0, '0, '0, 1'b0, 3'd0, '0);
        check("R12", observed(), {1'b1, 117'h0});

        // R12 result appears the cycle after the inputs, not in the same cycle
        offer_valid = 1'b1; offer_src = 24'h40; offer_prio = 8'h01;
        #1;
        check("R12", observed(), {1'b1, 117'h0});
        @(posedge clk);
        #1;
        offer_valid = 1'b0; offer_src = '0; offer_prio = '0;
        check("R12", observed(), {1'b1, 1'b0, 24'h0, 1'b1, 24'h30, 1'b0, 24'h0, 1'b0, 1'b0, 32'h0, 8'h0});

        // R1 mid-run reset clears pending interrupt and line
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        check("R1", observed(), '0);
        step(1'b0, '0, '0, 1'b1, 3'd2, '0);
        check("R1", observed(), {1'b0, 1'b0, 24'h0, 1'b0, 24'h0, 1'b0, 24'h0, 1'b0, 1'b1, 32'h0, 8'hFF});
        // R1 pending priority was 0xFF: accept moved it into the priority field
        step(1'b0, '0, '0, 1'b1, 3'd4, '0);
        check("R1", observed(), {1'b0, 1'b0, 24'h0, 1'b0, 24'h0, 1'b0, 24'h0, 1'b0, 1'b1, 32'hFF000000, 8'hFF});

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R12: watchdog expired, got hang expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule